// File: doc/BRIEF.md
# Synchronous Serial Shift Slave

This block is an 8-bit shift-register peripheral for a bus on which another device owns the serial clock. There is no word-framing line. The block brings the external clock into the system clock domain and turns its transitions into capture and drive events. It shifts received data in and transmit data out, least significant bit first. A polarity input picks which transition captures data and which one drives data.

The host side is a pair of holding registers. Writing `wr_data` fills the transmit holder and clears `tx_empty`. A completed incoming byte lands in `rd_data` and raises `rx_full`. A one-cycle `rd_en` pulse acknowledges that byte.

Between words the data line returns to its idle level, which is a driven high or, with the open-drain option, a released output. The bit counter is the only record of word alignment. A missed clock transition therefore shifts every later byte, and only a reset restores alignment.

Top module: `serial_shift_slave`

## Requirements
- R1: With `cfg_pol`=0 data is captured on the rising edge of `sclk_in`; with `cfg_pol`=1 it is captured on the falling edge. Bits arrive least significant first. After the eighth capture, `rd_data` holds the byte and `rx_full` is 1.
- R2: Transmit bits change on the opposite edge of `sclk_in` (falling for `cfg_pol`=0, rising for `cfg_pol`=1), least significant bit first. Each bit is valid on `txd_o` before the following capture edge.
- R3: Bit 7 is truncated. `HOLD_CYC` system cycles after the eighth capture edge is detected, the line goes back to idle, well before the next word's first drive edge.
- R4: With `cfg_odrain`=0, `txd_oe` is 1 at all times and the idle line is 1. With `cfg_odrain`=1, `txd_oe` is 1 only while a word is being shifted out and 0 otherwise.
- R5: `tx_empty` is 1 after reset and goes to 0 one cycle after a write. It returns to 1 at the capture edge of bit 1 of the word being sent. A write in that same cycle wins, and the flag stays 0.
- R6: The byte for the next word is frozen at the capture edge of bit 6. A write after that point causes the current word to be sent again, and the new byte follows it. A write before that point is sent as the next word.
- R7: An `rd_en` pulse clears `rx_full`. If a byte completes in the same cycle as the read, `rx_full` stays 1 and `rd_data` shows the new byte.
- R8: If `sclk_in` stops mid-word, both shift registers, the bit counter and `txd_o` hold their values. The word then completes correctly when edges resume.
- R9: A synchronous reset clears the bit counter, the shift registers and `rd_data`, sets `tx_empty`, clears `rx_full`, and returns the line to idle. A steady clock level during reset causes no false edge.
- R10: No error is flagged on a lost edge. After 7 bits of one word and 1 bit of the next, `rd_data` is the misaligned byte {new bit 0, old bits 6..0}. A reset realigns the word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pol | input | 1 | Edge polarity: 0 captures on rise, 1 captures on fall |
| cfg_odrain | input | 1 | Release the data output while no word is sent |
| sclk_in | input | 1 | External serial clock, asynchronous |
| rxd_in | input | 1 | Serial receive data |
| txd_o | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Output enable for the transmit pad |
| wr_en | input | 1 | Host write strobe for the transmit holder |
| wr_data | input | WIDTH (8) | Transmit byte |
| tx_empty | output | 1 | Transmit holder may be refilled |
| rd_en | input | 1 | Host read acknowledge |
| rd_data | output | WIDTH (8) | Last received byte |
| rx_full | output | 1 | A received byte is waiting |

## Verification
Two pairs of events can land in the same system cycle. The first pair is a host write and the bit-1 capture that sets `tx_empty`. The second pair is a host read and the bit-7 capture that completes a byte. The bench counts the two register stages of the synchronizer and the edge register, and places the strobe exactly in the cycle where the capture edge takes effect. For the first pair it then requires that `tx_empty` stays 0. For the second pair it requires that `rx_full` stays 1 and that `rd_data` already holds the new byte.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef struct packed {
    logic capture;
    logic drive;
  } sclk_events_t;
endpackage

// File: rtl/sss_edge_detect.sv
module sss_edge_detect
  import sss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         pol,
  input  logic         sclk_in,
  input  logic         rxd_in,
  output sclk_events_t events,
  output logic         rxd_sync
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sclk_q;
  logic [MSB:0] rxd_q;
  logic         sclk_prev;
  logic         rise, fall;

  // Preload on reset so a steady clock level shows no edge afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= {SYNC_STAGES{sclk_in}};
      rxd_q     <= {SYNC_STAGES{rxd_in}};
      sclk_prev <= sclk_in;
    end else begin
      sclk_q    <= {sclk_q[MSB-1:0], sclk_in};
      rxd_q     <= {rxd_q[MSB-1:0], rxd_in};
      sclk_prev <= sclk_q[MSB];
    end
  end

  assign rise     = sclk_q[MSB] & ~sclk_prev;
  assign fall     = ~sclk_q[MSB] & sclk_prev;
  assign rxd_sync = rxd_q[MSB];

  always_comb begin
    events.capture = pol ? fall : rise;
    events.drive   = pol ? rise : fall;
  end
endmodule

// File: rtl/sss_rx.sv
module sss_rx #(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic                     rxd,
  input  logic                     rd_en,
  output logic [$clog2(WIDTH)-1:0] bit_idx,
  output logic [WIDTH-1:0]         rd_data,
  output logic                     rx_full
);
  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [WIDTH-1:0] shreg;
  logic [WIDTH-1:0] shreg_next;
  logic             word_done;

  assign shreg_next = {rxd, shreg[WIDTH-1:1]};
  assign word_done  = capture && (bit_idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bit_idx <= '0;
      rd_data <= '0;
      rx_full <= 1'b0;
    end else begin
      if (capture) begin
        shreg   <= shreg_next;
        bit_idx <= word_done ? '0 : bit_idx + 1'b1;
      end
      if (word_done) rd_data <= shreg_next;
      if (word_done)  rx_full <= 1'b1;
      else if (rd_en) rx_full <= 1'b0;
    end
  end

  AST_FULL_AFTER_WORD: assert property (@(posedge clk) disable iff (rst)
    word_done |=> rx_full); // R1
  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !word_done) |=> !rx_full); // R7
  AST_IDX_HELD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(bit_idx) && $stable(shreg)); // R8
endmodule

// File: rtl/sss_tx.sv
module sss_tx #(
  parameter int WIDTH    = 8,
  parameter int HOLD_CYC = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture,
  input  logic                     drive,
  input  logic [$clog2(WIDTH)-1:0] bit_idx,
  input  logic                     odrain,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  output logic                     txd_o,
  output logic                     txd_oe,
  output logic                     tx_empty
);
  localparam int CW = $clog2(WIDTH);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST     = CW'(WIDTH - 1);
  localparam logic [CW-1:0] FREEZE   = CW'(WIDTH - 2);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC - 1);

  logic [WIDTH-1:0] tx_hold;
  logic [WIDTH-1:0] next_word;
  logic [WIDTH-1:0] shreg;
  logic             lock;
  logic             active;
  logic             ending;
  logic [HW-1:0]    hold_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_hold   <= '0;
      next_word <= '0;
      shreg     <= '0;
      lock      <= 1'b0;
      active    <= 1'b0;
      ending    <= 1'b0;
      hold_cnt  <= '0;
      tx_empty  <= 1'b1;
      txd_o     <= 1'b1;
      txd_oe    <= ~odrain;
    end else begin
      if (wr_en) tx_hold <= wr_data;
      if (!lock) next_word <= tx_hold;
      if (capture && bit_idx == FREEZE) lock <= 1'b1;

      if (drive) begin
        if (!active) begin
          shreg  <= next_word;
          active <= 1'b1;
          lock   <= 1'b0;
        end else begin
          shreg <= shreg >> 1;
        end
      end

      if (capture && bit_idx == LAST) begin
        ending   <= 1'b1;
        hold_cnt <= '0;
      end else if (ending) begin
        if (hold_cnt == HOLD_END) begin
          ending <= 1'b0;
          active <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end

      if (wr_en) tx_empty <= 1'b0;
      else if (capture && bit_idx == CW'(1)) tx_empty <= 1'b1;

      txd_o  <= active ? shreg[0] : 1'b1;
      txd_oe <= active | ~odrain;
    end
  end

  AST_EMPTY_AT_BIT1: assert property (@(posedge clk) disable iff (rst)
    (capture && bit_idx == CW'(1) && !wr_en) |=> tx_empty); // R5
  AST_WRITE_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_empty); // R5
  AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (odrain && !active) |=> !txd_oe); // R4
  AST_NEXT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(next_word)); // R6
endmodule

// File: rtl/serial_shift_slave.sv
module serial_shift_slave
  import sss_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_pol,
  input  logic             cfg_odrain,
  input  logic             sclk_in,
  input  logic             rxd_in,
  output logic             txd_o,
  output logic             txd_oe,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             tx_empty,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rx_full
);
  localparam int CW = $clog2(WIDTH);

  sclk_events_t  ev;
  logic          rxd_s;
  logic [CW-1:0] bit_idx;

  sss_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pol(cfg_pol), .sclk_in(sclk_in),
    .rxd_in(rxd_in), .events(ev), .rxd_sync(rxd_s)
  );

  sss_rx #(.WIDTH(WIDTH)) u_rx (
    .clk(clk), .rst(rst), .capture(ev.capture), .rxd(rxd_s),
    .rd_en(rd_en), .bit_idx(bit_idx), .rd_data(rd_data), .rx_full(rx_full)
  );

  sss_tx #(.WIDTH(WIDTH), .HOLD_CYC(HOLD_CYC)) u_tx (
    .clk(clk), .rst(rst), .capture(ev.capture), .drive(ev.drive),
    .bit_idx(bit_idx), .odrain(cfg_odrain), .wr_en(wr_en),
    .wr_data(wr_data), .txd_o(txd_o), .txd_oe(txd_oe), .tx_empty(tx_empty)
  );
endmodule

// File: tb/tb_serial_shift_slave.sv
`timescale 1ns/1ps
module tb_serial_shift_slave;
  localparam int H = 20;
  // {pol, odrain, tx byte, rx byte}
  localparam logic [17:0] VEC [0:5] = '{
    18'h0A53C, 18'h25AC3, 18'h1817E, 18'h3FF00, 18'h000FF, 18'h29669
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pol_r = 1'b0, odr_r = 1'b0;
  logic sclk = 1'b1, rxd = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd_o, txd_oe, tx_empty, rx_full;
  logic [7:0] rd_data;
  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  serial_shift_slave dut (
    .clk(clk), .rst(rst), .cfg_pol(pol_r), .cfg_odrain(odr_r),
    .sclk_in(sclk), .rxd_in(rxd), .txd_o(txd_o), .txd_oe(txd_oe),
    .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
    .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_dut(input logic p, input logic od);
    @(negedge clk);
    pol_r = p; odr_r = od; sclk = ~p; rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // One serial bit; optional host strobe placed in the cycle the capture edge takes effect
  task automatic do_bit(input logic b, input logic swr, input logic srd,
                        input logic [7:0] wd, output logic t, output logic oe);
    @(negedge clk);
    sclk = pol_r; rxd = b;
    repeat (H) @(negedge clk);
    t = txd_o; oe = txd_oe;
    sclk = ~pol_r;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr_en = swr; rd_en = srd; if (swr) wr_data = wd;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic do_word(input logic [7:0] rb, output logic [7:0] tb, output logic oe_all);
    logic t, o;
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      do_bit(rb[i], 1'b0, 1'b0, 8'h00, t, o);
      tb[i] = t; oe_all &= o;
    end
  endtask

  initial begin
    logic [7:0] tb_byte;
    logic oe_all, t, o;

    // R9: reset state
    reset_dut(1'b0, 1'b0);
    chk("R9 txd idle", txd_o, 1'b1);
    chk("R9 oe", txd_oe, 1'b1);
    chk("R9 tx_empty", tx_empty, 1'b1);
    chk("R9 rx_full", rx_full, 1'b0);
    chk("R9 rd_data", rd_data, 8'h00);

    // Table walk: R1 R2 R3 R4
    for (int v = 0; v < 6; v++) begin
      reset_dut(VEC[v][17], VEC[v][16]);
      chk("R4 oe before word", txd_oe, !VEC[v][16]);
      host_write(VEC[v][15:8]);
      do_word(VEC[v][7:0], tb_byte, oe_all);
      chk("R2 tx byte", tb_byte, VEC[v][15:8]);
      chk("R4 oe during word", oe_all, 1'b1);
      chk("R1 rx byte", rd_data, VEC[v][7:0]);
      chk("R1 rx_full", rx_full, 1'b1);
      chk("R3 idle after word", {txd_oe, txd_o}, VEC[v][16] ? {1'b0, 1'b1} : 2'b11);
      host_read();
      chk("R7 read clears", rx_full, 1'b0);
    end

    // R5: empty timing and write/bit-1 coincidence
    reset_dut(1'b0, 1'b0);
    host_write(8'h3C);
    do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);
    chk("R5 empty after bit0", tx_empty, 1'b0);
    do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);
    chk("R5 empty after bit1", tx_empty, 1'b1);
    for (int i = 2; i < 8; i++) do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);
    do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);
    do_bit(1'b0, 1'b1, 1'b0, 8'hC3, t, o);
    chk("R5 write wins at bit1", tx_empty, 1'b0);
    for (int i = 2; i < 8; i++) do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);

    // R6: late write retransmits, early write does not
    reset_dut(1'b0, 1'b0);
    host_write(8'hA1);
    for (int i = 0; i < 8; i++) begin
      do_bit(1'b0, i == 7, 1'b0, 8'h4E, t, o);
      tb_byte[i] = t;
    end
    chk("R6 first word", tb_byte, 8'hA1);
    do_word(8'h00, tb_byte, oe_all);
    chk("R6 retransmitted", tb_byte, 8'hA1);
    for (int i = 0; i < 8; i++) begin
      do_bit(1'b0, i == 3, 1'b0, 8'h77, t, o);
      tb_byte[i] = t;
    end
    chk("R6 new after retransmit", tb_byte, 8'h4E);
    do_word(8'h00, tb_byte, oe_all);
    chk("R6 early write next", tb_byte, 8'h77);

    // R7: read in same cycle as byte completion
    reset_dut(1'b1, 1'b0);
    do_word(8'h11, tb_byte, oe_all);
    for (int i = 0; i < 8; i++) do_bit(((8'hE7 >> i) & 1) != 0, 1'b0, i == 7, 8'h00, t, o);
    chk("R7 full kept", rx_full, 1'b1);
    chk("R7 new byte", rd_data, 8'hE7);

    // R8: clock stall mid-word
    reset_dut(1'b0, 1'b0);
    host_write(8'hB6);
    for (int i = 0; i < 4; i++) begin
      do_bit(((8'h2D >> i) & 1) != 0, 1'b0, 1'b0, 8'h00, t, o);
      tb_byte[i] = t;
    end
    repeat (300) @(negedge clk);
    chk("R8 line held", txd_o, 1'b0);
    chk("R8 no byte", rx_full, 1'b0);
    for (int i = 4; i < 8; i++) begin
      do_bit(((8'h2D >> i) & 1) != 0, 1'b0, 1'b0, 8'h00, t, o);
      tb_byte[i] = t;
    end
    chk("R8 tx resumed", tb_byte, 8'hB6);
    chk("R8 rx resumed", rd_data, 8'h2D);

    // R10: lost edge misaligns; reset realigns
    reset_dut(1'b0, 1'b0);
    for (int i = 0; i < 7; i++) do_bit(((8'h5A >> i) & 1) != 0, 1'b0, 1'b0, 8'h00, t, o);
    chk("R10 no flag", rx_full, 1'b0);
    do_bit(1'b1, 1'b0, 1'b0, 8'h00, t, o);
    chk("R10 misaligned byte", rd_data, 8'hDA);
    for (int i = 0; i < 3; i++) do_bit(1'b0, 1'b0, 1'b0, 8'h00, t, o);
    reset_dut(1'b0, 1'b0);
    chk("R9 mid-word reset idle", {txd_oe, txd_o, rx_full}, 3'b110);
    do_word(8'h5A, tb_byte, oe_all);
    chk("R10 realigned", rd_data, 8'h5A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule